// File: doc/BRIEF.md
# Static RAM Expansion Card Bus Decoder

This block sits between the asynchronous bus of a 68000-class processor and a 1 MB static RAM expansion card. The card is organised as sixteen banks. Each bank is a pair of byte-wide devices that together hold one 16-bit word. From the word address, the address strobe, the two data strobes, the read/write line and a system power indication, the block produces four groups of signals:

- the bank chip selects;
- one output enable shared by all devices;
- a write enable for each byte lane;
- the direction and enable controls for the data-bus transceivers.

It also supplies the inverted word address that the RAM devices expect.

The decoder holds no state, and every output is a combinational function of the present inputs. The host decides when the data is valid from its own fixed cycle timing, so the card gives no ready handshake. The card claims only the 1 MB window whose upper address nibble (A23..A20) equals binary 0001, which is the range $100000 to $1FFFFF. Inside that window, A19..A16 pick the bank.

Top module: `sram_card_decoder`

## Requirements
- R1: The card is selected only while `asN` is low and `busAddr[23:20]` equals 4'b0001. A23, A22 and A21 must be low and A20 must be high.
- R2: When `busAddr[23:20]` is any value other than 4'b0001, all sixteen bits of `bankCsN` are high.
- R3: When the card is selected and `sysPwrN` is low, exactly one bit of `bankCsN` is low. That bit's index equals `busAddr[19:16]`, and the same select serves both byte devices of the bank.
- R4: While `asN` is high, all bits of `bankCsN` are high, whatever the address.
- R5: `ramOeN` is low exactly when the card is selected, `rdWr` is 1 (read), and at least one of `udsN` or `ldsN` is low.
- R6: `ramWeHiN` is low exactly when the card is selected, `rdWr` is 0 (write) and `udsN` is low.
- R7: `ramWeLoN` is low exactly when the card is selected, `rdWr` is 0 and `ldsN` is low.
- R8: `xcvrDir` equals `rdWr` at all times, with no inversion.
- R9: `xcvrEnN` is low exactly when at least one of `ramOeN`, `ramWeHiN` or `ramWeLoN` is low.
- R10: `ramAddr[k]` equals the inverse of `busAddr[k+1]` for k = 0..14.
- R11: When `sysPwrN` is high (sleep or shutdown), all bits of `bankCsN` are high. The enables still follow R5 to R7.
- R12: At no time is more than one bit of `bankCsN` low. All outputs respond to the present inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busAddr | input | 23 | Processor word address, bits 23 down to 1 |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper data strobe, active low |
| ldsN | input | 1 | Lower data strobe, active low |
| rdWr | input | 1 | 1 = read cycle, 0 = write cycle |
| sysPwrN | input | 1 | Low while the system is fully powered; high in sleep or shutdown |
| bankCsN | output | 16 | Bank chip selects, active low, one per byte pair |
| ramAddr | output | 15 | Inverted word address to the RAM devices |
| ramOeN | output | 1 | Output enable shared by all RAM devices, active low |
| ramWeHiN | output | 1 | Upper byte lane write enable, active low |
| ramWeLoN | output | 1 | Lower byte lane write enable, active low |
| xcvrDir | output | 1 | Data transceiver direction, a copy of rdWr |
| xcvrEnN | output | 1 | Data transceiver enable, active low |

## Verification
The block has no state, so a fault in the decode shows up in the same evaluation as the input pattern that exposes it. The faults it can show are:

- a bank select that goes low for the wrong address nibble;
- two selects low at once;
- a select that ignores the strobe or power qualification;
- a write enable that fires for the wrong byte lane.

A bad window compare shows up only for particular values of A23..A20. A bad lane gate shows up only for particular strobe combinations. For that reason every combination of window bits, bank bits, strobes, direction and power is applied and compared at the ports.

// File: rtl/sram_dec_pkg.sv
package sram_dec_pkg;

  // Qualified strobes handed from the control decode to the datapath.
  // All fields are active high; the datapath converts to bus polarity.
  typedef struct packed {
    logic cardSel;   // address strobe low and window matched
    logic csEnable;  // card selected and system powered
    logic readEn;    // shared output enable request
    logic writeHi;   // upper lane write request
    logic writeLo;   // lower lane write request
    logic dirRead;   // transceiver direction, read toward the bus
  } ctrlStrobes_t;

  localparam int unsigned DefaultAddrHi   = 23;
  localparam int unsigned DefaultBankBits = 4;
  localparam int unsigned DefaultWordBits = 15;

endpackage

// File: rtl/sram_dec_ctrl.sv
module sram_dec_ctrl
  import sram_dec_pkg::*;
#(
  parameter int unsigned TAG_BITS = 4,
  parameter logic [TAG_BITS-1:0] WIN_TAG = 4'b0001
) (
  input  logic [TAG_BITS-1:0] addrTag,
  input  logic                asN,
  input  logic                udsN,
  input  logic                ldsN,
  input  logic                rdWr,
  input  logic                sysPwrN,
  output ctrlStrobes_t        strobes
);

  logic winHit;
  logic anyLane;
  logic powered;

  always_comb begin
    winHit  = (addrTag == WIN_TAG);
    anyLane = ~udsN | ~ldsN;
    powered = ~sysPwrN;

    strobes          = '0;
    strobes.cardSel  = winHit & ~asN;
    strobes.csEnable = strobes.cardSel & powered;
    strobes.readEn   = strobes.cardSel & rdWr & anyLane;
    strobes.writeHi  = strobes.cardSel & ~rdWr & ~udsN;
    strobes.writeLo  = strobes.cardSel & ~rdWr & ~ldsN;
    strobes.dirRead  = rdWr;
  end

endmodule

// File: rtl/sram_dec_path.sv
module sram_dec_path
  import sram_dec_pkg::*;
#(
  parameter int unsigned BANK_BITS = 4,
  parameter int unsigned WORD_BITS = 15,
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS
) (
  input  ctrlStrobes_t          strobes,
  input  logic [BANK_BITS-1:0]  bankField,
  input  logic [WORD_BITS-1:0]  wordField,
  output logic [NUM_BANKS-1:0]  bankCsN,
  output logic [WORD_BITS-1:0]  ramAddr,
  output logic                  ramOeN,
  output logic                  ramWeHiN,
  output logic                  ramWeLoN,
  output logic                  xcvrDir,
  output logic                  xcvrEnN
);

  // One comparator per bank: low only for the matching bank number.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_BITS-1:0] BankId = BANK_BITS'(b);
    always_comb begin
      bankCsN[b] = ~(strobes.csEnable & (bankField == BankId));
    end
  end

  // The address lines to the devices are inverted one bit at a time.
  for (genvar k = 0; k < WORD_BITS; k++) begin : g_addr
    always_comb begin
      ramAddr[k] = ~wordField[k];
    end
  end

  always_comb begin
    ramOeN   = ~strobes.readEn;
    ramWeHiN = ~strobes.writeHi;
    ramWeLoN = ~strobes.writeLo;
    xcvrDir  = strobes.dirRead;
    xcvrEnN  = ~(strobes.readEn | strobes.writeHi | strobes.writeLo);
  end

endmodule

// File: rtl/sram_card_decoder.sv
module sram_card_decoder
  import sram_dec_pkg::*;
#(
  parameter int unsigned ADDR_HI   = DefaultAddrHi,
  parameter int unsigned BANK_BITS = DefaultBankBits,
  parameter int unsigned WORD_BITS = DefaultWordBits,
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS,
  localparam int unsigned BANK_LO   = WORD_BITS + 1,
  localparam int unsigned TAG_LO    = BANK_LO + BANK_BITS,
  localparam int unsigned TAG_BITS  = ADDR_HI - TAG_LO + 1
) (
  input  logic [ADDR_HI:1]       busAddr,
  input  logic                   asN,
  input  logic                   udsN,
  input  logic                   ldsN,
  input  logic                   rdWr,
  input  logic                   sysPwrN,
  output logic [NUM_BANKS-1:0]   bankCsN,
  output logic [WORD_BITS-1:0]   ramAddr,
  output logic                   ramOeN,
  output logic                   ramWeHiN,
  output logic                   ramWeLoN,
  output logic                   xcvrDir,
  output logic                   xcvrEnN
);

  localparam logic [TAG_BITS-1:0] WinTag = TAG_BITS'(1);

  ctrlStrobes_t strobes;

  sram_dec_ctrl #(
    .TAG_BITS (TAG_BITS),
    .WIN_TAG  (WinTag)
  ) u_ctrl (
    .addrTag (busAddr[ADDR_HI:TAG_LO]),
    .asN     (asN),
    .udsN    (udsN),
    .ldsN    (ldsN),
    .rdWr    (rdWr),
    .sysPwrN (sysPwrN),
    .strobes (strobes)
  );

  sram_dec_path #(
    .BANK_BITS (BANK_BITS),
    .WORD_BITS (WORD_BITS)
  ) u_path (
    .strobes   (strobes),
    .bankField (busAddr[TAG_LO-1:BANK_LO]),
    .wordField (busAddr[WORD_BITS:1]),
    .bankCsN   (bankCsN),
    .ramAddr   (ramAddr),
    .ramOeN    (ramOeN),
    .ramWeHiN  (ramWeHiN),
    .ramWeLoN  (ramWeLoN),
    .xcvrDir   (xcvrDir),
    .xcvrEnN   (xcvrEnN)
  );

endmodule

// File: rtl/sram_card_decoder_chk.sv
module sram_card_decoder_chk #(
  parameter int unsigned ADDR_HI   = 23,
  parameter int unsigned BANK_BITS = 4,
  parameter int unsigned WORD_BITS = 15,
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS,
  localparam int unsigned TAG_LO    = WORD_BITS + 1 + BANK_BITS
) (
  input logic [ADDR_HI:1]     busAddr,
  input logic                 asN,
  input logic                 udsN,
  input logic                 ldsN,
  input logic                 rdWr,
  input logic                 sysPwrN,
  input logic [NUM_BANKS-1:0] bankCsN,
  input logic [WORD_BITS-1:0] ramAddr,
  input logic                 ramOeN,
  input logic                 ramWeHiN,
  input logic                 ramWeLoN,
  input logic                 xcvrDir,
  input logic                 xcvrEnN
);

  logic outsideWin;
  assign outsideWin = (busAddr[ADDR_HI:TAG_LO] != 1);

  always_comb begin
    // R12
    cs_onehot_chk: assert ($onehot0(~bankCsN));
    // R2
    cs_outside_chk: assert (!outsideWin || (&bankCsN));
    // R4
    cs_strobe_chk: assert (!asN || (&bankCsN));
    // R11
    cs_sleep_chk: assert (!sysPwrN || (&bankCsN));
    // R6
    we_hi_lane_chk: assert (ramWeHiN || (!rdWr && !udsN && !asN));
    // R7
    we_lo_lane_chk: assert (ramWeLoN || (!rdWr && !ldsN && !asN));
    // R5
    oe_read_chk: assert (ramOeN || (rdWr && !asN && (!udsN || !ldsN)));
    // R9
    xcvr_en_chk: assert (xcvrEnN == (ramOeN && ramWeHiN && ramWeLoN));
  end

endmodule

bind sram_card_decoder sram_card_decoder_chk #(
  .ADDR_HI   (ADDR_HI),
  .BANK_BITS (BANK_BITS),
  .WORD_BITS (WORD_BITS)
) u_chk (.*);

// File: tb/sram_card_decoder_bench.sv
module sram_card_decoder_bench;

  localparam int ClkPeriod = 10;

  typedef struct packed {
    logic [15:0] cs;
    logic [14:0] addr;
    logic        oe;
    logic        weHi;
    logic        weLo;
    logic        dir;
    logic        en;
    logic [3:0]  csReq;  // requirement number that governs the select outcome
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:1] busAddr = '0;
  logic        asN = 1'b1, udsN = 1'b1, ldsN = 1'b1, rdWr = 1'b1, sysPwrN = 1'b0;
  logic [15:0] bankCsN;
  logic [14:0] ramAddr;
  logic        ramOeN, ramWeHiN, ramWeLoN, xcvrDir, xcvrEnN;

  int testsRun = 0;
  int testsFailed = 0;
  bit allDone = 1'b0;
  expItem_t expQ[$];

  always #(ClkPeriod/2) clk = ~clk;

  sram_card_decoder u_sram_card_decoder (
    .busAddr  (busAddr),
    .asN      (asN),
    .udsN     (udsN),
    .ldsN     (ldsN),
    .rdWr     (rdWr),
    .sysPwrN  (sysPwrN),
    .bankCsN  (bankCsN),
    .ramAddr  (ramAddr),
    .ramOeN   (ramOeN),
    .ramWeHiN (ramWeHiN),
    .ramWeLoN (ramWeLoN),
    .xcvrDir  (xcvrDir),
    .xcvrEnN  (xcvrEnN)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Driver: applies one bus pattern and queues the outcome the requirements predict.
  task automatic drive(input logic [23:1] a, input logic as, input logic uds,
                       input logic lds, input logic rw, input logic pwr);
    expItem_t e;
    logic sel;
    @(posedge clk);
    #1;
    busAddr = a; asN = as; udsN = uds; ldsN = lds; rdWr = rw; sysPwrN = pwr;
    sel = (a[23:20] == 4'b0001) && !as;            // R1
    e.cs = 16'hFFFF;
    if (sel && !pwr) e.cs[a[19:16]] = 1'b0;        // R3
    if (pwr)                e.csReq = 4'd11;
    else if (as)            e.csReq = 4'd4;
    else if (a[23:20] != 1) e.csReq = 4'd2;
    else                    e.csReq = 4'd3;
    e.addr = ~a[15:1];                              // R10
    e.oe   = !(sel && rw && (!uds || !lds));        // R5
    e.weHi = !(sel && !rw && !uds);                 // R6
    e.weLo = !(sel && !rw && !lds);                 // R7
    e.dir  = rw;                                    // R8
    e.en   = e.oe && e.weHi && e.weLo;              // R9
    expQ.push_back(e);
  endtask

  // Monitor: compares away from the driving edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      string csTag;
      e = expQ.pop_front();
      case (e.csReq)
        4'd11:   csTag = "R11 power-down selects";
        4'd4:    csTag = "R4 strobe-idle selects";
        4'd2:    csTag = "R2 outside-window selects";
        default: csTag = "R1/R3 in-window bank select";
      endcase
      check(bankCsN == e.cs, csTag, 32'(bankCsN), 32'(e.cs));
      check($countones(~bankCsN) <= 1, "R12 at most one select",
            32'($countones(~bankCsN)), 32'd1);
      check(ramAddr == e.addr, "R10 inverted address", 32'(ramAddr), 32'(e.addr));
      check(ramOeN == e.oe, "R5 output enable", 32'(ramOeN), 32'(e.oe));
      check(ramWeHiN == e.weHi, "R6 upper write enable", 32'(ramWeHiN), 32'(e.weHi));
      check(ramWeLoN == e.weLo, "R7 lower write enable", 32'(ramWeLoN), 32'(e.weLo));
      check(xcvrDir == e.dir, "R8 transceiver direction", 32'(xcvrDir), 32'(e.dir));
      check(xcvrEnN == e.en, "R9 transceiver enable", 32'(xcvrEnN), 32'(e.en));
    end
  end

  initial begin
    // Reset state: idle bus, all controls inactive.
    drive(23'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Full sweep of window nibble, bank nibble, strobes, direction and power.
    for (int tag = 0; tag < 16; tag++) begin
      for (int bank = 0; bank < 16; bank++) begin
        for (int ctl = 0; ctl < 32; ctl++) begin
          logic [14:0] word;
          word = 15'((tag * 16 + bank) * 2731 + ctl * 97);
          drive({4'(tag), 4'(bank), word}, ctl[0], ctl[1], ctl[2], ctl[3], ctl[4]);
        end
      end
    end

    // Address inversion corners inside the window (R10).
    drive({4'b0001, 4'hF, 15'h7FFF}, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive({4'b0001, 4'h0, 15'h0000}, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive({4'b0001, 4'h5, 15'h5555}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    repeat (3) @(posedge clk);
    allDone = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!allDone) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule